// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host CPU sequential access to a packet buffer memory through one data port. Software first loads a starting address and a byte count through a small byte-wide register window. It then issues repeated data-port accesses. Each access moves one, two or four bytes at the current address. After each access the engine advances the address, folds it back inside the configured receive ring, and reduces the remaining count. When the count runs out, a completion flag is raised in the interrupt status register.

The buffer memory has sparse valid regions: a small low region and a larger window placed higher in the address space. Writes that fall outside these regions are dropped, and reads from outside them return all ones. The interrupt output is the OR of the status bits that the mask enables, taken over the low seven bits only. Status bits are cleared by writing ones to them. If a register write and a data-port access arrive in the same cycle, the register write takes effect and the access is dropped.

The default parameters place the window at 0x0400..0x07FF, which keeps the storage small. A full-size build sets `WIN_BASE` to 16384 and `WIN_BYTES` to 32768.

Top module: `rdma_port`

## Requirements
- R1: After reset the register window reads as follows: status 0x80, mask 0x00, config 0x00, address 0x0000, count 0x0000. `irq_o` is low.
- R2: The access width is 4 bytes when `dp_quad_i` is high. Otherwise it is 2 bytes when config (offset 3) bit 0 is 1, and 1 byte when that bit is 0. After each effective access the address advances by the access width.
- R3: When the advanced address equals stop page (offset 9) times 256, the address is reloaded with start page (offset 8) times 256.
- R4: When the remaining count is less than or equal to the access width, the count becomes 0 and status bit 6 is set. Otherwise the count drops by the access width.
- R5: A data-port write while the count is 0 changes nothing: the memory, the address and the count all keep their values. A data-port read while the count is 0 still advances the address.
- R6: Valid memory consists of the addresses below `LOW_BYTES` and the addresses from `WIN_BASE` up to `WIN_BASE+WIN_BYTES-1`. Any byte lane outside both regions is not written and reads as 0xFF.
- R7: For 2- and 4-byte accesses, address bit 0 is taken as 0. Data is little-endian: bits 7:0 go to the lowest address. Unused upper read lanes return 0.
- R8: Writing the command register (offset 0) with bits 1:0 set to 01 (read) or 10 (write) while the count is 0 sets status bit 6 at once.
- R9: `irq_o` is high exactly when (status AND mask AND 0x7F) is nonzero. Status bit 7 never drives it.
- R10: Writing the status register (offset 1) clears the status bits written as 1, for bits 6:0 only. Status bit 7 is cleared only by a write to the command register.
- R11: The address is loaded through offsets 4 (low byte) and 5 (high byte), and reads back from the same offsets. The count uses offsets 6 and 7 in the same way. The start and stop pages read back from offsets 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| dp_req_i | input | 1 | Data-port access strobe |
| dp_we_i | input | 1 | Data-port direction, 1 = write |
| dp_quad_i | input | 1 | Selects a 4-byte access |
| dp_wdata_i | input | 32 | Data-port write data |
| dp_rdata_o | output | 32 | Data-port read data at the current address |
| irq_o | output | 1 | Interrupt output |

## Verification
Byte-wide writes followed by byte-wide reads check that the address advances in single steps and that the count ends exactly at completion. Word accesses that start at an odd address separate correct forced alignment and byte ordering from a design that keeps bit 0 or swaps the lanes. Quad accesses, together with an access that straddles the end of the window, show whether the validity check is made per byte lane rather than once per access. A word access that lands exactly on the stop page, a write attempted with the count at zero, and a command issued with a zero count each target one of the corner rules on its own.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int PG_W   = 8;

  localparam logic [3:0] REG_CMD     = 4'h0;
  localparam logic [3:0] REG_STATUS  = 4'h1;
  localparam logic [3:0] REG_MASK    = 4'h2;
  localparam logic [3:0] REG_CFG     = 4'h3;
  localparam logic [3:0] REG_ADDR_LO = 4'h4;
  localparam logic [3:0] REG_ADDR_HI = 4'h5;
  localparam logic [3:0] REG_CNT_LO  = 4'h6;
  localparam logic [3:0] REG_CNT_HI  = 4'h7;
  localparam logic [3:0] REG_START   = 4'h8;
  localparam logic [3:0] REG_STOP    = 4'h9;

  localparam int DONE_BIT = 6;
  localparam int HOLD_BIT = 7;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } dma_op_e;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [3:0]      addr_i,
  input  logic [7:0]      wdata_i,
  input  logic            done_set_i,
  input  logic            cnt_zero_i,
  output logic [7:0]      cmd_o,
  output logic [7:0]      status_o,
  output logic [7:0]      mask_o,
  output logic [7:0]      cfg_o,
  output logic [PG_W-1:0] start_pg_o,
  output logic [PG_W-1:0] stop_pg_o,
  output logic            irq_o
);
  logic cmd_wr, st_wr, zero_len;
  logic [7:0] status_d;
  dma_op_e op;

  assign cmd_wr   = we_i && (addr_i == REG_CMD);
  assign st_wr    = we_i && (addr_i == REG_STATUS);
  assign op       = dma_op_e'(wdata_i[1:0]);
  assign zero_len = cmd_wr && (op == OP_READ || op == OP_WRITE) && cnt_zero_i;

  always_comb begin
    status_d = status_o;
    if (st_wr) status_d[6:0] = status_o[6:0] & ~wdata_i[6:0];
    if (cmd_wr) status_d[HOLD_BIT] = 1'b0;
    if (done_set_i || zero_len) status_d[DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= '0;
      status_o   <= 8'h80;
      mask_o     <= '0;
      cfg_o      <= '0;
      start_pg_o <= '0;
      stop_pg_o  <= '0;
    end else begin
      status_o <= status_d;
      if (cmd_wr) cmd_o <= wdata_i;
      if (we_i && addr_i == REG_MASK)  mask_o     <= wdata_i;
      if (we_i && addr_i == REG_CFG)   cfg_o      <= wdata_i;
      if (we_i && addr_i == REG_START) start_pg_o <= wdata_i;
      if (we_i && addr_i == REG_STOP)  stop_pg_o  <= wdata_i;
    end
  end

  assign irq_o = |(status_o[6:0] & mask_o[6:0]);

  assert_w1c_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && wdata_i[6:0] == 7'h7f && !done_set_i) |=> status_o[6:0] == 7'h00);
  assert_hold_bit_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr |=> status_o[HOLD_BIT] == $past(status_o[HOLD_BIT]));
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_addr_lo_i,
  input  logic              ld_addr_hi_i,
  input  logic              ld_cnt_lo_i,
  input  logic              ld_cnt_hi_i,
  input  logic [7:0]        ld_data_i,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [2:0]        nbytes_i,
  input  logic [ADDR_W-1:0] ring_start_i,
  input  logic [ADDR_W-1:0] ring_stop_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              fire_o,
  output logic              done_o
);
  logic ld_any, last;
  logic [ADDR_W-1:0] sum, addr_nx;

  assign ld_any  = ld_addr_lo_i | ld_addr_hi_i | ld_cnt_lo_i | ld_cnt_hi_i;
  assign fire_o  = acc_i && (!we_i || cnt_o != '0);
  assign sum     = addr_o + ADDR_W'(nbytes_i);
  assign addr_nx = (sum == ring_stop_i) ? ring_start_i : sum;
  assign last    = cnt_o <= CNT_W'(nbytes_i);
  assign done_o  = fire_o && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
    end else if (ld_any) begin
      if (ld_addr_lo_i) addr_o[7:0]        <= ld_data_i;
      if (ld_addr_hi_i) addr_o[15:8]       <= ld_data_i;
      if (ld_cnt_lo_i)  cnt_o[7:0]         <= ld_data_i;
      if (ld_cnt_hi_i)  cnt_o[15:8]        <= ld_data_i;
    end else if (fire_o) begin
      addr_o <= addr_nx;
      cnt_o  <= last ? '0 : cnt_o - CNT_W'(nbytes_i);
    end
  end

  assert_cnt_monotone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !ld_any) |=> cnt_o <= $past(cnt_o));
  assert_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && we_i && cnt_o == '0 && !ld_any) |=> (addr_o == $past(addr_o) && cnt_o == '0));
  assert_wrap_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !ld_any && ring_start_i != ring_stop_i) |=> addr_o != $past(ring_stop_i));
endmodule

// File: rtl/rdma_buf.sv
module rdma_buf
  import rdma_pkg::*;
#(
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 1024,
  parameter int WIN_BYTES = 1024
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [2:0]        nbytes_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam int DEPTH = LOW_BYTES + WIN_BYTES;
  localparam int IW    = $clog2(DEPTH);
  localparam int LANES = 4;

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] lane_idx [LANES];
  logic [LANES-1:0] lane_ok, lane_en;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] a;
      logic in_low, in_win;
      a = 32'(base_i) + 32'(l);
      in_low = a < 32'(LOW_BYTES);
      in_win = (a >= 32'(WIN_BASE)) && (a < 32'(WIN_BASE + WIN_BYTES));
      lane_ok[l] = in_low || in_win;
      lane_en[l] = 32'(l) < 32'(nbytes_i);
      if (in_low)      lane_idx[l] = IW'(a);
      else if (in_win) lane_idx[l] = IW'(a - 32'(WIN_BASE) + 32'(LOW_BYTES));
      else             lane_idx[l] = '0;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++)
      if (we_i && lane_en[l] && lane_ok[l]) mem[lane_idx[l]] <= wdata_i[8*l +: 8];
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (!lane_en[l])     rdata_o[8*l +: 8] = 8'h00;
      else if (lane_ok[l]) rdata_o[8*l +: 8] = mem[lane_idx[l]];
      else                 rdata_o[8*l +: 8] = 8'hff;
    end
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 1024,
  parameter int WIN_BYTES = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        dp_req_i,
  input  logic        dp_we_i,
  input  logic        dp_quad_i,
  input  logic [31:0] dp_wdata_i,
  output logic [31:0] dp_rdata_o,
  output logic        irq_o
);
  logic [7:0] cmd, status, mask, cfg;
  logic [PG_W-1:0] start_pg, stop_pg;
  logic [ADDR_W-1:0] addr, base;
  logic [CNT_W-1:0] cnt;
  logic [2:0] nbytes;
  logic acc, fire, done;

  assign acc    = dp_req_i && !reg_we_i;
  assign nbytes = dp_quad_i ? 3'd4 : (cfg[0] ? 3'd2 : 3'd1);
  assign base   = (nbytes == 3'd1) ? addr : {addr[ADDR_W-1:1], 1'b0};

  rdma_regs u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .done_set_i (done),
    .cnt_zero_i (cnt == '0),
    .cmd_o      (cmd),
    .status_o   (status),
    .mask_o     (mask),
    .cfg_o      (cfg),
    .start_pg_o (start_pg),
    .stop_pg_o  (stop_pg),
    .irq_o      (irq_o)
  );

  rdma_engine u_eng (
    .clk_i, .rst_ni,
    .ld_addr_lo_i (reg_we_i && reg_addr_i == REG_ADDR_LO),
    .ld_addr_hi_i (reg_we_i && reg_addr_i == REG_ADDR_HI),
    .ld_cnt_lo_i  (reg_we_i && reg_addr_i == REG_CNT_LO),
    .ld_cnt_hi_i  (reg_we_i && reg_addr_i == REG_CNT_HI),
    .ld_data_i    (reg_wdata_i),
    .acc_i        (acc),
    .we_i         (dp_we_i),
    .nbytes_i     (nbytes),
    .ring_start_i ({start_pg, 8'h00}),
    .ring_stop_i  ({stop_pg, 8'h00}),
    .addr_o       (addr),
    .cnt_o        (cnt),
    .fire_o       (fire),
    .done_o       (done)
  );

  rdma_buf #(.LOW_BYTES(LOW_BYTES), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_buf (
    .clk_i,
    .base_i   (base),
    .nbytes_i (nbytes),
    .we_i     (fire && dp_we_i),
    .wdata_i  (dp_wdata_i),
    .rdata_o  (dp_rdata_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      REG_CMD:     reg_rdata_o = cmd;
      REG_STATUS:  reg_rdata_o = status;
      REG_MASK:    reg_rdata_o = mask;
      REG_CFG:     reg_rdata_o = cfg;
      REG_ADDR_LO: reg_rdata_o = addr[7:0];
      REG_ADDR_HI: reg_rdata_o = addr[15:8];
      REG_CNT_LO:  reg_rdata_o = cnt[7:0];
      REG_CNT_HI:  reg_rdata_o = cnt[15:8];
      REG_START:   reg_rdata_o = start_pg;
      REG_STOP:    reg_rdata_o = stop_pg;
      default:     reg_rdata_o = 8'h00;
    endcase
  end

  assert_done_on_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cnt != '0 && cnt <= CNT_W'(nbytes)) |=> status[DONE_BIT]);
  assert_zero_len_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_CMD && (reg_wdata_i[1:0] == 2'b01 || reg_wdata_i[1:0] == 2'b10)
     && cnt == '0) |=> status[DONE_BIT]);
endmodule

// File: tb/rdma_port_test.sv
module rdma_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, dp_req = 0, dp_we = 0, dp_quad = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [31:0] dp_wdata = 0, dp_rdata;
  logic irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rdma_port uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .dp_req_i(dp_req), .dp_we_i(dp_we), .dp_quad_i(dp_quad),
    .dp_wdata_i(dp_wdata), .dp_rdata_o(dp_rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic get16(logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    reg_rd(lo, l); reg_rd(lo + 4'd1, h); v = {h, l};
  endtask

  task automatic set_addr(logic [15:0] a);
    reg_wr(4'h4, a[7:0]); reg_wr(4'h5, a[15:8]);
  endtask

  task automatic set_cnt(logic [15:0] c);
    reg_wr(4'h6, c[7:0]); reg_wr(4'h7, c[15:8]);
  endtask

  task automatic dp_wr(logic [31:0] d, logic q);
    @(negedge clk); dp_req = 1; dp_we = 1; dp_quad = q; dp_wdata = d;
    @(negedge clk); dp_req = 0; dp_we = 0; dp_quad = 0;
  endtask

  task automatic dp_rd(logic q, output logic [31:0] v);
    @(negedge clk); dp_req = 1; dp_we = 0; dp_quad = q; #1 v = dp_rdata;
    @(negedge clk); dp_req = 0; dp_quad = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v; logic [15:0] w;
    reg_rd(4'h1, v); chk("R1 status", v, 8'h80);
    reg_rd(4'h2, v); chk("R1 mask", v, 8'h00);
    reg_rd(4'h3, v); chk("R1 cfg", v, 8'h00);
    get16(4'h4, w);  chk("R1 addr", w, 16'h0000);
    get16(4'h6, w);  chk("R1 cnt", w, 16'h0000);
    chk("R1 irq", irq, 1'b0);
    reg_wr(4'h2, 8'h80); #1 chk("R9 bit7 no irq", irq, 1'b0);
    reg_wr(4'h1, 8'hff); reg_rd(4'h1, v); chk("R10 bit7 not w1c", v, 8'h80);
    reg_wr(4'h0, 8'h00); reg_rd(4'h1, v); chk("R10 cmd clears bit7", v, 8'h00);
    reg_wr(4'h2, 8'h00);
  endtask

  task automatic t_bytes();
    logic [7:0] v; logic [15:0] w; logic [31:0] d;
    reg_wr(4'h3, 8'h00); set_addr(16'h0000); set_cnt(16'h0004);
    dp_wr(32'h11, 0); dp_wr(32'h22, 0);
    get16(4'h4, w); chk("R2 byte addr step", w, 16'h0002);
    get16(4'h6, w); chk("R4 cnt minus", w, 16'h0002);
    reg_rd(4'h1, v); chk("R4 no done yet", v, 8'h00);
    set_addr(16'h0000); set_cnt(16'h0002);
    dp_rd(0, d); chk("R2 byte rd0", d, 32'h11);
    dp_rd(0, d); chk("R2 byte rd1", d, 32'h22);
    get16(4'h6, w); chk("R4 cnt zero", w, 16'h0000);
    reg_rd(4'h1, v); chk("R4 done set", v, 8'h40);
    reg_wr(4'h1, 8'h40); reg_rd(4'h1, v); chk("R10 w1c done", v, 8'h00);
    set_addr(16'h1234); reg_rd(4'h4, v); chk("R11 addr lo", v, 8'h34);
    reg_rd(4'h5, v); chk("R11 addr hi", v, 8'h12);
  endtask

  task automatic t_words();
    logic [15:0] w; logic [31:0] d; logic [7:0] v;
    reg_wr(4'h3, 8'h01); set_addr(16'h0401); set_cnt(16'h0003);
    dp_wr(32'hA1B2, 0);
    get16(4'h4, w); chk("R2 word addr step", w, 16'h0403);
    get16(4'h6, w); chk("R4 cnt 3-2", w, 16'h0001);
    dp_wr(32'hC3D4, 0);
    get16(4'h6, w); chk("R4 saturate", w, 16'h0000);
    reg_rd(4'h1, v); chk("R4 done word", v, 8'h40);
    reg_wr(4'h1, 8'h7f);
    reg_wr(4'h3, 8'h00); set_addr(16'h0400); set_cnt(16'h0004);
    dp_rd(0, d); chk("R7 lane0 low addr", d, 32'hB2);
    dp_rd(0, d); chk("R7 lane1", d, 32'hA1);
    dp_rd(0, d); chk("R7 odd aligned lo", d, 32'hD4);
    dp_rd(0, d); chk("R7 odd aligned hi", d, 32'hC3);
    reg_wr(4'h3, 8'h01); set_addr(16'h0401); set_cnt(16'h0002);
    dp_rd(0, d); chk("R7 word read", d, 32'h0000A1B2);
    reg_wr(4'h1, 8'h7f);
  endtask

  task automatic t_quad();
    logic [15:0] w; logic [31:0] d;
    reg_wr(4'h2, 8'h40);
    set_addr(16'h0410); set_cnt(16'h0008);
    dp_wr(32'h44332211, 1); dp_wr(32'h88776655, 1);
    get16(4'h4, w); chk("R2 quad addr", w, 16'h0418);
    reg_wr(4'h1, 8'h7f);
    set_addr(16'h0410); set_cnt(16'h0005);
    dp_rd(1, d); chk("R7 quad rd0", d, 32'h44332211);
    get16(4'h6, w); chk("R4 cnt 5-4", w, 16'h0001);
    chk("R9 irq low before done", irq, 1'b0);
    dp_rd(1, d); chk("R7 quad rd1", d, 32'h88776655);
    #1 chk("R9 irq on done", irq, 1'b1);
    reg_wr(4'h1, 8'h40); #1 chk("R9 irq cleared", irq, 1'b0);
    reg_wr(4'h2, 8'h00);
  endtask

  task automatic t_ring();
    logic [15:0] w; logic [7:0] v;
    reg_wr(4'h8, 8'h04); reg_wr(4'h9, 8'h06);
    reg_rd(4'h8, v); chk("R11 start page", v, 8'h04);
    reg_rd(4'h9, v); chk("R11 stop page", v, 8'h06);
    reg_wr(4'h3, 8'h01); set_addr(16'h05FE); set_cnt(16'h0006);
    dp_wr(32'hBEEF, 0);
    get16(4'h4, w); chk("R3 wrap to start", w, 16'h0400);
    get16(4'h6, w); chk("R3 cnt after wrap", w, 16'h0004);
    set_addr(16'h05FC); dp_wr(32'h1111, 0);
    get16(4'h4, w); chk("R3 no wrap short", w, 16'h05FE);
    reg_wr(4'h1, 8'h7f);
  endtask

  task automatic t_sparse();
    logic [31:0] d; logic [15:0] w;
    reg_wr(4'h3, 8'h00); set_addr(16'h0100); set_cnt(16'h0001);
    dp_wr(32'h5A, 0);
    get16(4'h6, w); chk("R6 cnt still counts", w, 16'h0000);
    set_addr(16'h0100); set_cnt(16'h0001);
    dp_rd(0, d); chk("R6 hole reads ff", d, 32'h000000FF);
    set_addr(16'h001F); set_cnt(16'h0001); dp_wr(32'h77, 0);
    set_addr(16'h001F); set_cnt(16'h0001);
    dp_rd(0, d); chk("R6 low region", d, 32'h77);
    reg_wr(4'h3, 8'h01); set_addr(16'h07FE); set_cnt(16'h0002); dp_wr(32'h6655, 0);
    set_addr(16'h07FE); set_cnt(16'h0004);
    dp_rd(1, d); chk("R6 per lane window end", d, 32'hFFFF6655);
    reg_wr(4'h1, 8'h7f);
  endtask

  task automatic t_ignore();
    logic [31:0] d; logic [15:0] w;
    reg_wr(4'h3, 8'h00); set_addr(16'h0420); set_cnt(16'h0001); dp_wr(32'h11, 0);
    set_addr(16'h0420);
    dp_wr(32'h99, 0);
    get16(4'h4, w); chk("R5 addr held", w, 16'h0420);
    get16(4'h6, w); chk("R5 cnt held", w, 16'h0000);
    set_cnt(16'h0001);
    dp_rd(0, d); chk("R5 mem untouched", d, 32'h11);
    dp_rd(0, d);
    get16(4'h4, w); chk("R5 read at zero advances", w, 16'h0422);
    reg_wr(4'h1, 8'h7f);
  endtask

  task automatic t_zero();
    logic [7:0] v;
    set_cnt(16'h0000); reg_wr(4'h1, 8'h7f);
    reg_wr(4'h0, 8'h02); reg_rd(4'h1, v); chk("R8 zero len write cmd", v, 8'h40);
    reg_wr(4'h1, 8'h7f);
    reg_wr(4'h0, 8'h01); reg_rd(4'h1, v); chk("R8 zero len read cmd", v, 8'h40);
    reg_wr(4'h1, 8'h7f);
    reg_wr(4'h0, 8'h00); reg_rd(4'h1, v); chk("R8 no op no done", v, 8'h00);
    set_cnt(16'h0005);
    reg_wr(4'h0, 8'h01); reg_rd(4'h1, v); chk("R8 nonzero cnt no done", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bytes();
    t_words();
    t_quad();
    t_ring();
    t_sparse();
    t_ignore();
    t_zero();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule